// File: doc/BRIEF.md
# Eight-Channel Alarm Change Interrupt Register Bank

This block is the byte-wide control and status register bank of an eight-channel line interface. It watches two 8-bit alarm vectors coming from the channels, one reporting loss of incoming signal and one reporting a failure of the line driver. Each bit is brought into the local clock domain and compared with its previous value. Any change, whether the alarm rises or clears, leaves a sticky per-bit change flag. Software clears a flag by writing a 1 to that bit.

The flags of both groups are masked by per-bit enable registers. The masked results are merged into one registered, active-low interrupt line. The bank also holds a 4-bit selector that tells an external performance monitor which channel to watch, and an 8-bit per-channel digital loopback enable. A write of any value to the reset address clears the whole bank one cycle later.

Access is through a simple synchronous bus with address, write data, write strobe, read strobe and registered read data.

Top module: `alarm_irq_regbank`

## Requirements
- R1: After the asynchronous reset, every register reads 00h, `irq_n` is 1, and `mon_sel` and `loop_en` are 0.
- R2: The signal-loss enable at address 06h and the driver-failure enable at 07h store the written byte. A read presents the addressed value on `bus_rdata` at the clock edge that samples `bus_re`, and `bus_rdata` holds that value while `bus_re` is low.
- R3: Change flag bit n of a group (signal loss at 08h, driver failure at 09h) becomes 1 when input bit n changes value in either direction. The flag is readable three clock edges after the edge that first samples the new input, and it stays 1 until it is cleared.
- R4: Writing to 08h or 09h clears the flags whose write-data bits are 1 and leaves the other flags alone. A change detected in the same cycle as the clear keeps its flag at 1.
- R5: `irq_n` goes to 0 one edge after any flag is 1 while its enable bit in the same group is 1. The two groups share the line. A flag whose enable is 0 does not drive the line low.
- R6: `irq_n` returns to 1 one edge after the last enabled flag is cleared, or after the enable bit of the last enabled flag is cleared.
- R7: A write of any data to address 0Ah sets every register to 00h and `irq_n` to 1 at the next clock edge. Bus accesses and input changes that fall in that one cycle are discarded.
- R8: The monitor selector at 0Bh drives `mon_sel` from write-data bits [3:0]. Bits [7:4] always read as 0.
- R9: Bit n of the loopback register at 0Ch drives `loop_en[n]`, which is the loopback enable of channel n.
- R10: Reads of any address other than 06h to 0Ch return 00h. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| sig_loss_i | input | 8 | Per-channel loss-of-signal alarm, asynchronous |
| drv_fail_i | input | 8 | Per-channel driver-failure alarm, asynchronous |
| irq_n | output | 1 | Merged interrupt, active low |
| mon_sel | output | 4 | Channel selector for the external performance monitor |
| loop_en | output | 8 | Per-channel digital loopback enable |

## Verification
An alarm edge driven before clock edge k sets its flag at edge k+2 and pulls `irq_n` low at edge k+3. Read data and register writes settle at the edge that samples the strobe. A clear or an enable change moves `irq_n` one edge after the write, and a soft reset acts one edge after its write. The bench holds a behavioural model that uses a queue of sampled alarm values for the synchronizer delay. Inputs change only on falling edges, and model and design are compared on every falling edge, so each result is checked in exactly the cycle it is due. The directed checks wait at least five cycles after an alarm edge. The one exception is a clear that is deliberately aimed at the detection edge, to exercise the collision rule of R4.

// File: rtl/alarm_regbank_pkg.sv
package alarm_regbank_pkg;

    localparam int ADDR_W = 8;
    typedef logic [ADDR_W-1:0] addr_t;

    // Register offsets: software decodes these, so they are fixed.
    localparam addr_t OFS_LOS_EN   = 8'h06;
    localparam addr_t OFS_DRV_EN   = 8'h07;
    localparam addr_t OFS_LOS_CHG  = 8'h08;
    localparam addr_t OFS_DRV_CHG  = 8'h09;
    localparam addr_t OFS_SOFT_RST = 8'h0A;
    localparam addr_t OFS_MON_SEL  = 8'h0B;
    localparam addr_t OFS_LOOP     = 8'h0C;

    localparam int NUM_GROUPS = 2;

    // Change-flag offset of alarm group g (0: signal loss, 1: driver failure).
    function automatic addr_t chg_ofs(input int g);
        return (g == 0) ? OFS_LOS_CHG : OFS_DRV_CHG;
    endfunction

endpackage

// File: rtl/alarm_sync_detect.sv
module alarm_sync_detect #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] change
);
    // chain_q[0..STAGES-1] synchronise the input; chain_q[STAGES] holds the
    // synchronised value one cycle older.
    logic [STAGES:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i <= STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign change = chain_q[STAGES-1] ^ chain_q[STAGES];

endmodule

// File: rtl/alarm_flag_group.sv
module alarm_flag_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic [W-1:0] change,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] flags
);
    logic [W-1:0] flags_d, flags_q;

    always_comb begin
        if (soft_clr) flags_d = '0;
        else          flags_d = (flags_q & ~clr_mask) | change;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

endmodule

// File: rtl/alarm_irq_regbank.sv
module alarm_irq_regbank
    import alarm_regbank_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int MON_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] sig_loss_i,
    input  logic [DATA_W-1:0] drv_fail_i,
    output logic              irq_n,
    output logic [MON_W-1:0]  mon_sel,
    output logic [DATA_W-1:0] loop_en
);
    localparam int CH     = DATA_W;
    localparam int MON_PAD = DATA_W - MON_W;

    typedef struct packed {
        logic [CH-1:0]     los_en;
        logic [CH-1:0]     drv_en;
        logic [MON_W-1:0]  mon;
        logic [CH-1:0]     loop;
        logic              srst;
        logic              irq_n;
        logic [DATA_W-1:0] rdata;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [NUM_GROUPS-1:0][CH-1:0] raw_in, chg, flg, clr;
    logic [DATA_W-1:0]             rd_val;

    assign raw_in[0] = sig_loss_i;
    assign raw_in[1] = drv_fail_i;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign clr[g] = (bus_we && !bank_q.srst && bus_addr == chg_ofs(g))
                        ? bus_wdata : '0;

        alarm_sync_detect #(.W(CH), .STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_in[g]),
            .change   (chg[g])
        );

        alarm_flag_group #(.W(CH)) u_flags (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (bank_q.srst),
            .change   (chg[g]),
            .clr_mask (clr[g]),
            .flags    (flg[g])
        );
    end

    always_comb begin
        case (bus_addr)
            OFS_LOS_EN:  rd_val = bank_q.los_en;
            OFS_DRV_EN:  rd_val = bank_q.drv_en;
            OFS_LOS_CHG: rd_val = flg[0];
            OFS_DRV_CHG: rd_val = flg[1];
            OFS_MON_SEL: rd_val = {{MON_PAD{1'b0}}, bank_q.mon};
            OFS_LOOP:    rd_val = bank_q.loop;
            default:     rd_val = '0;
        endcase
    end

    always_comb begin
        bank_d       = bank_q;
        bank_d.srst  = 1'b0;
        bank_d.irq_n = !(|((flg[0] & bank_q.los_en) | (flg[1] & bank_q.drv_en)));
        if (bank_q.srst) begin
            bank_d       = '0;
            bank_d.irq_n = 1'b1;
        end else begin
            if (bus_re) bank_d.rdata = rd_val;
            if (bus_we) begin
                case (bus_addr)
                    OFS_LOS_EN:   bank_d.los_en = bus_wdata;
                    OFS_DRV_EN:   bank_d.drv_en = bus_wdata;
                    OFS_MON_SEL:  bank_d.mon    = bus_wdata[MON_W-1:0];
                    OFS_LOOP:     bank_d.loop   = bus_wdata;
                    OFS_SOFT_RST: bank_d.srst   = 1'b1;
                    default:      ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q       <= '0;
            bank_q.irq_n <= 1'b1;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign bus_rdata = bank_q.rdata;
    assign irq_n     = bank_q.irq_n;
    assign mon_sel   = bank_q.mon;
    assign loop_en   = bank_q.loop;

endmodule

// File: rtl/alarm_irq_regbank_chk.sv
module alarm_irq_regbank_chk
    import alarm_regbank_pkg::*;
#(
    parameter int DW = 8,
    parameter int MW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DW-1:0]     bus_rdata,
    input logic              irq_n,
    input logic [MW-1:0]     mon_sel,
    input logic [DW-1:0]     loop_en,
    input logic              soft_rst,
    input logic [DW-1:0]     los_flags,
    input logic [DW-1:0]     drv_flags,
    input logic [DW-1:0]     los_en,
    input logic [DW-1:0]     drv_en
);
    logic pending;
    assign pending = |((los_flags & los_en) | (drv_flags & drv_en));

    // R3: a flag only drops through a clear write to its address or a soft reset
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !(bus_we && bus_addr == OFS_LOS_CHG))
        |=> ((los_flags & $past(los_flags)) == $past(los_flags)));

    // R5: an enabled flag pulls the interrupt low one edge later
    a_r5_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && pending) |=> !irq_n);

    // R6: no enabled flag means the interrupt is released one edge later
    a_r6_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending) |=> irq_n);

    // R7: the soft reset pulse empties the bank
    a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (irq_n && mon_sel == '0 && loop_en == '0 && los_en == '0
                      && drv_en == '0 && los_flags == '0 && drv_flags == '0));

    // R8: upper selector bits never read back as 1
    a_r8_mon_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == OFS_MON_SEL) |=> (bus_rdata[DW-1:MW] == '0));

    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (bus_addr < OFS_LOS_EN || bus_addr > OFS_LOOP))
        |=> (bus_rdata == '0));

endmodule

bind alarm_irq_regbank alarm_irq_regbank_chk #(.DW(DATA_W), .MW(MON_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq_n     (irq_n),
    .mon_sel   (mon_sel),
    .loop_en   (loop_en),
    .soft_rst  (bank_q.srst),
    .los_flags (flg[0]),
    .drv_flags (flg[1]),
    .los_en    (bank_q.los_en),
    .drv_en    (bank_q.drv_en)
);

// File: tb/alarm_irq_regbank_bench.sv
`timescale 1ns/1ps
module alarm_irq_regbank_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic       bus_we = 1'b0, bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] sig_loss_i = '0, drv_fail_i = '0;
    logic       irq_n;
    logic [3:0] mon_sel;
    logic [7:0] loop_en;

    int vecs = 0;
    int fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    alarm_irq_regbank u_alarm_irq_regbank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .sig_loss_i(sig_loss_i), .drv_fail_i(drv_fail_i),
        .irq_n(irq_n), .mon_sel(mon_sel), .loop_en(loop_en)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_los_en, m_drv_en, m_los_f, m_drv_f, m_loop, m_rdata;
    logic [3:0] m_mon;
    logic       m_irq_n, m_srst;
    logic [7:0] h_los[$];
    logic [7:0] h_drv[$];

    function automatic logic [7:0] m_read(input logic [7:0] a);
        case (a)
            8'h06:   return m_los_en;
            8'h07:   return m_drv_en;
            8'h08:   return m_los_f;
            8'h09:   return m_drv_f;
            8'h0B:   return {4'h0, m_mon};
            8'h0C:   return m_loop;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_los_en = 0; m_drv_en = 0; m_los_f = 0; m_drv_f = 0;
            m_loop = 0; m_rdata = 0; m_mon = 0; m_irq_n = 1; m_srst = 0;
            h_los = '{8'h00, 8'h00, 8'h00};
            h_drv = '{8'h00, 8'h00, 8'h00};
        end else begin
            logic [7:0] c_los, c_drv;
            logic       nxt_irq;
            // a value sampled at edge e-2 against edge e-3 gives the change seen now
            c_los = h_los[1] ^ h_los[2];
            c_drv = h_drv[1] ^ h_drv[2];
            h_los.push_front(sig_loss_i); void'(h_los.pop_back());
            h_drv.push_front(drv_fail_i); void'(h_drv.pop_back());
            nxt_irq = !(|((m_los_f & m_los_en) | (m_drv_f & m_drv_en)));
            if (m_srst) begin
                m_los_en = 0; m_drv_en = 0; m_los_f = 0; m_drv_f = 0;
                m_loop = 0; m_rdata = 0; m_mon = 0; m_irq_n = 1; m_srst = 0;
            end else begin
                m_irq_n = nxt_irq;
                if (bus_re) m_rdata = m_read(bus_addr);
                m_los_f = (m_los_f & ~((bus_we && bus_addr == 8'h08) ? bus_wdata : 8'h00)) | c_los;
                m_drv_f = (m_drv_f & ~((bus_we && bus_addr == 8'h09) ? bus_wdata : 8'h00)) | c_drv;
                if (bus_we) begin
                    case (bus_addr)
                        8'h06: m_los_en = bus_wdata;
                        8'h07: m_drv_en = bus_wdata;
                        8'h0A: m_srst   = 1'b1;
                        8'h0B: m_mon    = bus_wdata[3:0];
                        8'h0C: m_loop   = bus_wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5/R6 irq_n",   {7'b0, irq_n}, {7'b0, m_irq_n});
            chk("R2 bus_rdata",  bus_rdata, m_rdata);
            chk("R8 mon_sel",    {4'b0, mon_sel}, {4'b0, m_mon});
            chk("R9 loop_en",    loop_en, m_loop);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        v = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
        chk("R1 loop_en", loop_en, 8'h00);
        for (int a = 6; a <= 12; a++) begin
            rd(8'(a), v);
            chk("R1 reset register", v, 8'h00);
        end

        // R2: enable registers
        wr(8'h06, 8'h0F);
        wr(8'h07, 8'hF0);
        rd(8'h06, v); chk("R2 los enable", v, 8'h0F);
        rd(8'h07, v); chk("R2 drv enable", v, 8'hF0);

        // R3 / R5: rising alarm on enabled bit 0
        @(negedge clk); sig_loss_i = 8'h01;
        idle(5);
        rd(8'h08, v); chk("R3 rise flag", v, 8'h01);
        chk("R5 irq low", {7'b0, irq_n}, 8'h00);
        @(negedge clk); sig_loss_i = 8'h00;
        idle(5);
        rd(8'h08, v); chk("R3 fall keeps flag", v, 8'h01);

        // R4 / R6: clear releases the line one edge later
        wr(8'h08, 8'h01);
        @(negedge clk);
        chk("R6 irq released after clear", {7'b0, irq_n}, 8'h01);
        rd(8'h08, v); chk("R4 flag cleared", v, 8'h00);

        // R5: masked flag does not interrupt; other group does
        @(negedge clk); sig_loss_i = 8'h10;
        idle(5);
        rd(8'h08, v); chk("R3 masked flag set", v, 8'h10);
        chk("R5 masked no irq", {7'b0, irq_n}, 8'h01);
        @(negedge clk); drv_fail_i = 8'h20;
        idle(5);
        chk("R5 drv group irq", {7'b0, irq_n}, 8'h00);
        wr(8'h07, 8'h00);
        @(negedge clk);
        chk("R6 irq released by enable", {7'b0, irq_n}, 8'h01);

        // R4: clear collides with a new change on bit 2
        @(negedge clk); drv_fail_i = 8'h24;
        @(negedge clk);
        wr(8'h09, 8'h04);
        rd(8'h09, v); chk("R4 change wins over clear", v, 8'h24);
        wr(8'h09, 8'h20);
        rd(8'h09, v); chk("R4 partial clear", v, 8'h04);

        // R8 / R9
        wr(8'h0B, 8'hFF);
        rd(8'h0B, v); chk("R8 upper bits zero", v, 8'h0F);
        chk("R8 mon_sel", {4'b0, mon_sel}, 8'h0F);
        wr(8'h0C, 8'hA5);
        chk("R9 loop_en", loop_en, 8'hA5);

        // R10: unmapped space
        wr(8'h05, 8'hFF);
        wr(8'h0E, 8'hFF);
        rd(8'h05, v); chk("R10 unmapped read", v, 8'h00);
        rd(8'h0E, v); chk("R10 unmapped read", v, 8'h00);
        rd(8'h06, v); chk("R10 unmapped write no effect", v, 8'h0F);

        // R7: soft reset
        wr(8'h07, 8'hFF);
        @(negedge clk); drv_fail_i = 8'h00;
        idle(5);
        chk("R7 irq low before reset", {7'b0, irq_n}, 8'h00);
        wr(8'h0A, 8'h3C);
        @(negedge clk);
        chk("R7 irq high", {7'b0, irq_n}, 8'h01);
        chk("R7 loop_en", loop_en, 8'h00);
        chk("R7 mon_sel", {4'b0, mon_sel}, 8'h00);
        for (int a = 6; a <= 12; a++) begin
            rd(8'(a), v);
            chk("R7 register cleared", v, 8'h00);
        end

        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            bus_we    = ($urandom % 3) == 0;
            bus_re    = ($urandom % 2) == 0;
            bus_addr  = 8'(4 + ($urandom % 11));
            if (bus_addr == 8'h0A && ($urandom % 8) != 0) bus_addr = 8'h09;
            bus_wdata = 8'($urandom);
            if (($urandom % 6) == 0) sig_loss_i ^= 8'(1 << ($urandom % 8));
            if (($urandom % 6) == 0) drv_fail_i ^= 8'(1 << ($urandom % 8));
        end
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
        idle(4);

        summary();
        $finish;
    end

endmodule